// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Wakeup

This block sits between a group of maskable interrupt sources and a small 8-bit CPU core. Each source has an event input, an enable, a software clear pulse, a 2-bit software priority and a fixed index. An event sets the source's pending latch. The latch stays set until software clears it or until the CPU accepts the interrupt. A pending, enabled source can be served only when its priority is strictly above the CPU's running interrupt level. Among the sources that can be served, the highest priority wins. When priorities are equal, the lowest index wins.

The CPU sees a request line and a vector index, and accepts the interrupt with an acknowledge pulse. On acknowledge, the block pushes the running level onto a small stack and raises the level to the served priority. A return pulse pops the stack and restores the earlier level.

The block also drives two wake lines, one for Wait mode and one for Halt mode. Only sources marked by a parameter mask can wake the CPU from Halt. After such a wake, the next selection is limited to those sources. A higher-priority source that cannot wake from Halt is served right after that first one.

Top module: `irq_arbiter`

## Requirements
- R1: An event on a source sets its pending latch. The latch stays set while the source is disabled or its priority is not above the running level, and it is served once both conditions allow.
- R2: `irq_req` is high only when at least one source is pending, enabled and has a priority strictly greater than `cpu_level`.
- R3: `irq_vec` gives the index of the winning source: the highest priority wins, and on equal priority the lower index wins.
- R4: A clear pulse on a source drops its pending latch at the next clock edge. The clear also wins over an event on the same source in the same cycle.
- R5: An acknowledge while `irq_req` is high clears the pending latch of the served source and sets `cpu_level` to that source's priority on the next cycle. An event on the same source in the acknowledge cycle sets the latch again.
- R6: A `rti` pulse restores the level that was in force before the most recent acknowledge, and this works through nested levels. A `rti` with nothing stacked leaves `cpu_level` unchanged.
- R7: `wake_wait` is high whenever any source is both pending and enabled, whatever the running level.
- R8: `wake_halt` is high only when a pending, enabled source is marked halt-capable in `HALT_CAP`. A non-capable source alone leaves it low.
- R9: A `wake_halt` seen while `in_halt` is high limits the arbitration to halt-capable sources until the next acknowledge. After that acknowledge, the normal winner, which may be a non-capable source, is served.
- R10: When `cpu_level` is 3, `irq_req` stays low for every source, including sources with priority 3.
- R11: After reset, no source is pending, `cpu_level` is 0, and `irq_req`, `wake_wait` and `wake_halt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NSRC | One pulse per source: sets the pending latch |
| src_en | input | NSRC | Enable for each source |
| src_clr | input | NSRC | Software clear pulse for each source |
| src_prio | input | 2*NSRC | 2-bit priority per source; source i uses bits [2i+1:2i] |
| in_halt | input | 1 | CPU is in Halt mode |
| irq_ack | input | 1 | CPU accepts the current request |
| rti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | $clog2(NSRC) | Index of the winning source |
| cpu_level | output | 2 | Running interrupt level |
| wake_wait | output | 1 | Wake request for Wait mode |
| wake_halt | output | 1 | Wake request for Halt mode |

## Verification
Two things can hit the same source in the same cycle: a new event together with a software clear, and a new event together with the acknowledge that serves that source. The bench drives each pair in one cycle. It then judges the result only from the ports. After the clear case, the source must neither request nor wake. After the acknowledge case, the level must rise and the same source must request again once the level drops on return. A bench model that follows the requirements supplies the expected request, vector, level and wake values at every step, including the exhaustive sweep over all pending masks.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_TOP = prio_t'(2**PRIO_W - 1);
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NSRC = 6,
    parameter int VW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] clr,
    input  logic            take,
    input  logic [VW-1:0]   take_idx,
    output logic [NSRC-1:0] pend
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            logic served;
            served = take && (take_idx == VW'(i));
            st_d.pend[i] = ((st_q.pend[i] && !served) || evt[i]) && !clr[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> !pend[g]); // R4
        AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && !clr[g]) |=> pend[g]); // R1
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 6,
    parameter int VW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*PRIO_W-1:0] prio,
    input  prio_t                  level,
    output logic                   found,
    output logic [VW-1:0]          win
);
    prio_t best;

    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '0;
        for (int i = 0; i < NSRC; i++) begin
            prio_t p;
            p = prio[i*PRIO_W +: PRIO_W];
            if (cand[i] && (p > level) && (!found || p > best)) begin
                found = 1'b1;
                win   = VW'(i);
                best  = p;
            end
        end
    end

    AST_WIN_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[win]); // R2
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  prio_t push_prio,
    input  logic  pop,
    output prio_t level
);
    localparam int SPW = $clog2(DEPTH + 1);

    typedef struct packed {
        prio_t                  level;
        logic [SPW-1:0]         sp;
        logic [DEPTH-1:0][PRIO_W-1:0] stk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push && st_q.sp < SPW'(DEPTH)) begin
            st_d.stk[st_q.sp] = st_q.level;
            st_d.sp           = st_q.sp + 1'b1;
            st_d.level        = push_prio;
        end else if (pop && st_q.sp != '0) begin
            st_d.sp    = st_q.sp - 1'b1;
            st_d.level = st_q.stk[st_q.sp - 1'b1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;

    AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sp <= SPW'(DEPTH)); // R6
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.sp == '0) |=> $stable(level)); // R6
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int              NSRC     = 6,
    parameter int              DEPTH    = 4,
    parameter logic [NSRC-1:0] HALT_CAP = 6'b000101,
    localparam int             VW       = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_evt,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC-1:0]        src_clr,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic                   in_halt,
    input  logic                   irq_ack,
    input  logic                   rti,
    output logic                   irq_req,
    output logic [VW-1:0]          irq_vec,
    output logic [PRIO_W-1:0]      cpu_level,
    output logic                   wake_wait,
    output logic                   wake_halt
);
    typedef struct packed {
        logic restrict_on;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] pend_w, live_w, cand_w;
    logic            found_w, take_w;
    logic [VW-1:0]   win_w;
    prio_t           level_w, win_prio_w;

    irq_pend_bank #(.NSRC(NSRC), .VW(VW)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr(src_clr),
        .take(take_w), .take_idx(win_w), .pend(pend_w)
    );

    assign live_w = pend_w & src_en;
    assign cand_w = st_q.restrict_on ? (live_w & HALT_CAP) : live_w;

    irq_pick #(.NSRC(NSRC), .VW(VW)) u_pick (
        .clk(clk), .rst_n(rst_n), .cand(cand_w), .prio(src_prio),
        .level(level_w), .found(found_w), .win(win_w)
    );

    assign win_prio_w = src_prio[int'(win_w)*PRIO_W +: PRIO_W];
    assign take_w     = irq_ack && found_w;

    irq_level_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take_w), .push_prio(win_prio_w),
        .pop(rti), .level(level_w)
    );

    always_comb begin
        st_d = st_q;
        if (take_w)                       st_d.restrict_on = 1'b0;
        else if (in_halt && wake_halt)    st_d.restrict_on = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req   = found_w;
    assign irq_vec   = win_w;
    assign cpu_level = level_w;
    assign wake_wait = |live_w;
    assign wake_halt = |(live_w & HALT_CAP);

    AST_HALT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.restrict_on && irq_req) |-> HALT_CAP[irq_vec]); // R9
    AST_WAKE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        wake_halt |-> wake_wait); // R8
    AST_LVL3_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == PRIO_TOP) |-> !irq_req); // R10
    AST_LEVEL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> cpu_level > $past(cpu_level)); // R5
    AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake_wait); // R2
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
    localparam int N = 6;
    localparam logic [N-1:0] HC = 6'b000101;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] evt = '0, en = '1, clr = '0;
    logic [2*N-1:0] prio = '0;
    logic in_halt = 0, ack = 0, rti = 0;
    logic irq_req, wake_wait, wake_halt;
    logic [2:0] irq_vec;
    logic [1:0] cpu_level;

    int checks = 0, fails = 0;

    // bench model state
    logic [N-1:0] mpend = '0;
    int mlevel = 0, msp = 0;
    int mstk [4];
    bit mres = 0;

    always #10 clk = ~clk;

    irq_arbiter #(.NSRC(N), .DEPTH(4), .HALT_CAP(HC)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(evt), .src_en(en), .src_clr(clr),
        .src_prio(prio), .in_halt(in_halt), .irq_ack(ack), .rti(rti),
        .irq_req(irq_req), .irq_vec(irq_vec), .cpu_level(cpu_level),
        .wake_wait(wake_wait), .wake_halt(wake_halt)
    );

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic int pr(int i);
        return int'(prio[2*i +: 2]);
    endfunction

    function automatic int mwin();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (mpend[i] && en[i] && pr(i) > mlevel && (!mres || HC[i]))
                if (b < 0 || pr(i) > pr(b)) b = i;
        return b;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int w = mwin();
        chk({tag, " req"}, int'(irq_req), int'(w >= 0));
        if (w >= 0) chk({tag, " vec"}, int'(irq_vec), w);
        chk({tag, " level"}, int'(cpu_level), mlevel);
        chk({tag, " R7 wake_wait"}, int'(wake_wait), int'(|(mpend & en)));
        chk({tag, " R8 wake_halt"}, int'(wake_halt), int'(|(mpend & en & HC)));
    endtask

    // advance one clock, updating the model from the driven inputs
    task automatic tick();
        int w = mwin();
        bit af = ack && (w >= 0);
        bit wh = |(mpend & en & HC);
        logic [N-1:0] sv = '0;
        if (af) sv[w] = 1'b1;
        if (af) mres = 0;
        else if (in_halt && wh) mres = 1;
        mpend = ((mpend & ~sv) | evt) & ~clr;
        if (af) begin
            mstk[msp] = mlevel; msp++; mlevel = pr(w);
        end else if (rti && msp > 0) begin
            msp--; mlevel = mstk[msp];
        end
        @(posedge clk); #2;
        evt = '0; clr = '0; ack = 0; rti = 0;
        #1;
    endtask

    task automatic setp(int i, int p);
        prio[2*i +: 2] = 2'(p);
    endtask

    task automatic clear_all();
        clr = '1; tick();
    endtask

    initial begin
        #25; rst_n = 1;
        @(posedge clk); #3;
        chk("R11 reset req", int'(irq_req), 0);
        chk("R11 reset level", int'(cpu_level), 0);
        chk("R11 reset wake", int'(wake_wait | wake_halt), 0);

        // R1: disabled source stays pending, then served once enabled
        setp(3, 2); en = '0; evt[3] = 1; tick();
        chk("R1 disabled no req", int'(irq_req), 0);
        check_all("R1 disabled");
        en = '1; #1;
        chk("R1 enable req", int'(irq_req), 1);
        chk("R1 enable vec", int'(irq_vec), 3);
        clr[3] = 1; tick();
        chk("R4 clear drops", int'(irq_req), 0);
        check_all("R4");

        // R2/R5/R6 level sweep
        for (int l = 0; l < 3; l++) begin
            for (int p = 0; p < 4; p++) begin
                setp(0, l); setp(1, p);
                if (l > 0) begin
                    evt[0] = 1; tick(); ack = 1; tick();
                    chk("R5 level raised", int'(cpu_level), l);
                    check_all("R5 raise");
                end
                evt[1] = 1; tick();
                chk("R2 strict compare", int'(irq_req), int'(p > l));
                check_all("R2 sweep");
                clr[1] = 1; tick();
                if (l > 0) begin
                    rti = 1; tick();
                    chk("R6 restore", int'(cpu_level), 0);
                end
                check_all("R6 sweep");
            end
        end

        // R10: level 3 blocks everything
        setp(0, 3); evt[0] = 1; tick(); ack = 1; tick();
        chk("R10 level", int'(cpu_level), 3);
        for (int i = 1; i < N; i++) setp(i, 3);
        evt = 6'b111110; tick();
        chk("R10 blocked", int'(irq_req), 0);
        check_all("R10");
        clear_all(); rti = 1; tick(); check_all("R10 rti");

        // R3 exhaustive pending-mask sweep with two priority maps
        for (int mp = 0; mp < 2; mp++) begin
            for (int i = 0; i < N; i++) setp(i, mp == 0 ? (i * 5 + 1) % 4 : (i % 2) + 1);
            for (int m = 1; m < 64; m++) begin
                evt = 6'(m); tick();
                check_all("R3 sweep");
                clear_all();
            end
        end

        // R6 nested levels and empty rti
        setp(0, 1); setp(1, 2);
        evt[0] = 1; tick(); ack = 1; tick();
        evt[1] = 1; tick(); ack = 1; tick();
        chk("R6 nested top", int'(cpu_level), 2);
        rti = 1; tick(); chk("R6 nested pop1", int'(cpu_level), 1);
        rti = 1; tick(); chk("R6 nested pop2", int'(cpu_level), 0);
        rti = 1; tick(); chk("R6 empty rti", int'(cpu_level), 0);

        // R4: clear and event in the same cycle
        evt[2] = 1; clr[2] = 1; tick();
        chk("R4 clear beats evt", int'(wake_wait), 0);
        check_all("R4 same cycle");

        // R5: event on the served source in the ack cycle
        setp(2, 1); evt[2] = 1; tick();
        ack = 1; evt[2] = 1; tick();
        chk("R5 ack level", int'(cpu_level), 1);
        chk("R5 relatched wake", int'(wake_wait), 1);
        rti = 1; tick();
        chk("R5 relatched req", int'(irq_req), 1);
        check_all("R5 relatch");
        clear_all();

        // R7/R8/R9 halt behaviour
        in_halt = 1; setp(0, 1); setp(1, 3); setp(2, 2);
        evt[1] = 1; tick();
        chk("R7 wake_wait nonhalt", int'(wake_wait), 1);
        chk("R8 wake_halt nonhalt", int'(wake_halt), 0);
        check_all("R8");
        evt[0] = 1; tick();
        chk("R8 wake_halt capable", int'(wake_halt), 1);
        tick(); in_halt = 0; #1;
        chk("R9 first is capable", int'(irq_vec), 0);
        check_all("R9 restricted");
        ack = 1; tick();
        chk("R9 next is nonhalt", int'(irq_vec), 1);
        check_all("R9 after");
        ack = 1; tick(); check_all("R9 second ack");
        rti = 1; tick(); rti = 1; tick(); check_all("R9 unwind");
        clear_all(); check_all("R11 idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule